// File: doc/BRIEF.md
# Variable-Resolution Successive-Approximation Sequencer

This block runs the digital side of a successive-approximation converter. At run time it can be set to produce a 12-, 10-, 8- or 6-bit result. Each conversion has two phases. First comes a sampling phase, which has a fixed minimum and can be lengthened in whole converter cycles. Then comes one bit trial per result bit. The trials start at the most significant bit. For each trial the sequencer drives a trial word to the external DAC and reads back the comparator. It never runs trials for the bits below the selected resolution. The finished result is shifted right so that it is right-aligned.

The sequencer clock `clk` runs at twice the converter clock, so one tick is half a converter cycle. A conversion can be started in three ways: by setting the enable, by a software start pulse, or by an external trigger. The requested channel is latched when the conversion starts. The channel numbers include the on-die temperature sensor (16) and the reference voltage (17). A gated power-enable output serves those internal sources.

Top module: `sar_res_seq`

## Requirements
- R1: Out of reset the sequencer is idle, and busy, done, sample, dac_word, result and chan_sel are all zero. The resolution setting reads 00.
- R2: The resolution codes are 00 = 12 bits, 01 = 10 bits, 10 = 8 bits and 11 = 6 bits. For an analog value V on a 12-bit scale, the result is V shifted right by (12 - N). The comparator input is 1 when V is greater than or equal to dac_word.
- R3: A conversion keeps busy high for 3 + 2·E + 2·N + 1 ticks, where E is smp_extra. At E = 0 that is 14/12/10/8 converter cycles. The done output is high only in the last of those ticks.
- R4: A write to the resolution setting (res_wr) takes effect when enable is low. It is ignored when enable is high. The current setting is visible on res_mode.
- R5: While enable is high and the sequencer is idle, a conversion starts on a rising edge of enable, on sw_start, or on trig. Nothing starts while enable is low.
- R6: Clearing enable aborts a conversion in progress. Busy drops on the next tick, and no done pulse appears.
- R7: Each done pulse lasts one tick. The result holds its value until the next done.
- R8: A start request that arrives while busy is ignored and does not extend the conversion.
- R9: chan_sel is latched from chan_in when a conversion starts. sens_pwr equals sens_req AND enable.
- R10: The sample output is high exactly during the first 3 + 2·E ticks of a conversion. dac_word is zero outside the trial phase. While busy, the dac_word bits below bit (12 - N) stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, twice the converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Converter enable |
| res_wr | input | 1 | Resolution write strobe |
| res_in | input | 2 | Resolution code to write |
| smp_extra | input | SMPW | Extra sampling time in whole converter cycles |
| chan_in | input | 5 | Requested channel |
| sens_req | input | 1 | Request to power the temperature sensor and reference |
| sw_start | input | 1 | Software start pulse |
| trig | input | 1 | External trigger |
| cmp_in | input | 1 | Comparator output, 1 when the input is at or above the trial word |
| sample | output | 1 | High while sampling |
| dac_word | output | 12 | Trial word sent to the DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-tick result-valid strobe |
| result | output | 12 | Right-aligned result |
| chan_sel | output | 5 | Latched channel |
| sens_pwr | output | 1 | Gated sensor and reference enable |
| res_mode | output | 2 | Current resolution code |

## Verification
Conversions use analog values at the extremes (0 and full scale), at the mid-scale boundary (2047 and 2048), and with alternating bit patterns. Each value is run at all four resolutions. This shows whether a trial keeps or drops each bit, and whether the low bits are trimmed and shifted correctly. Runs at zero and nonzero extra sampling separate the sampling-phase count from the trial count. The three start sources are each used on their own. The bench also tries a start request during busy, a mid-conversion abort and a resolution write while enabled. These separate the start rules, the abort path and the lock on the resolution setting.

// File: rtl/sar_res_seq.sv
module sar_res_seq #(
  parameter int SMPW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            res_wr,
  input  logic [1:0]      res_in,
  input  logic [SMPW-1:0] smp_extra,
  input  logic [4:0]      chan_in,
  input  logic            sens_req,
  input  logic            sw_start,
  input  logic            trig,
  input  logic            cmp_in,
  output logic            sample,
  output logic [11:0]     dac_word,
  output logic            busy,
  output logic            done,
  output logic [11:0]     result,
  output logic [4:0]      chan_sel,
  output logic            sens_pwr,
  output logic [1:0]      res_mode
);
  localparam int CNTW = SMPW + 2;

  typedef enum logic [1:0] {IDLE, SAMP, CONV, FIN} st_t;

  st_t            st;
  logic [CNTW-1:0] cnt;
  logic [3:0]     bit_idx;
  logic           half;
  logic [11:0]    acc;
  logic           en_d;
  logic [3:0]     lsb;
  logic [11:0]    low_mask;
  logic [11:0]    acc_next;
  logic           go;

  assign lsb      = {1'b0, res_mode, 1'b0};
  assign low_mask = (12'd1 << lsb) - 12'd1;
  assign acc_next = cmp_in ? (acc | (12'd1 << bit_idx)) : acc;
  assign go       = en && (!en_d || sw_start || trig);

  assign busy     = (st != IDLE);
  assign sample   = (st == SAMP);
  assign done     = (st == FIN);
  assign dac_word = (st == CONV) ? (acc | (12'd1 << bit_idx)) : 12'd0;
  assign sens_pwr = sens_req & en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= IDLE;
      cnt      <= '0;
      bit_idx  <= 4'd11;
      half     <= 1'b0;
      acc      <= '0;
      en_d     <= 1'b0;
      result   <= '0;
      chan_sel <= '0;
      res_mode <= 2'b00;
    end else begin
      en_d <= en;
      if (res_wr && !en) res_mode <= res_in;
      if (!en) begin
        st <= IDLE;
      end else begin
        case (st)
          IDLE: if (go) begin
            st       <= SAMP;
            cnt      <= {1'b0, smp_extra, 1'b0} + CNTW'(2);
            chan_sel <= chan_in;
          end
          SAMP: begin
            if (cnt == '0) begin
              st      <= CONV;
              bit_idx <= 4'd11;
              half    <= 1'b0;
              acc     <= '0;
            end else begin
              cnt <= cnt - CNTW'(1);
            end
          end
          CONV: begin
            half <= ~half;
            if (half) begin
              acc <= acc_next;
              if (bit_idx == lsb) begin
                result <= acc_next >> lsb;
                st     <= FIN;
              end else begin
                bit_idx <= bit_idx - 4'd1;
              end
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  a_r4_res_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> $stable(res_mode));
  a_r6_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(chan_sel));
  a_r10_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((dac_word & low_mask) == 12'd0));
  a_r3_fin_after_trials: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(st == CONV));
endmodule

// File: tb/sar_res_seq_bench.sv
module sar_res_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, res_wr = 1'b0, sens_req = 1'b0, sw_start = 1'b0, trig = 1'b0;
  logic [1:0]  res_in = 2'b00;
  logic [3:0]  smp_extra = 4'd0;
  logic [4:0]  chan_in = 5'd0;
  logic        cmp_in;
  logic        sample, busy, done, sens_pwr;
  logic [11:0] dac_word, result;
  logic [4:0]  chan_sel;
  logic [1:0]  res_mode;
  int          vin = 0;

  int checks = 0, errors = 0;
  int m_cnt = 0, m_T = 0, m_S = 0, m_shift = 0, m_res = 0, m_chan = 0, m_cfg = 0;
  bit m_en_d = 0;
  bit model_on = 0;

  always #4 clk = ~clk;

  assign cmp_in = (vin >= int'(dac_word));

  sar_res_seq u_sar_res_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .res_wr(res_wr), .res_in(res_in),
    .smp_extra(smp_extra), .chan_in(chan_in), .sens_req(sens_req),
    .sw_start(sw_start), .trig(trig), .cmp_in(cmp_in), .sample(sample),
    .dac_word(dac_word), .busy(busy), .done(done), .result(result),
    .chan_sel(chan_sel), .sens_pwr(sens_pwr), .res_mode(res_mode)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_res = 0; m_chan = 0; m_cfg = 0; m_en_d = 0;
    end else begin
      if (m_cnt > 0) begin
        if (!en) m_cnt = 0;
        else begin
          m_cnt--;
          if (m_cnt == 1) m_res = vin >> m_shift;
        end
      end else if (en && (!m_en_d || sw_start || trig)) begin
        m_shift = 2 * m_cfg;
        m_S = 3 + 2 * int'(smp_extra);
        m_T = m_S + 2 * (12 - m_shift) + 1;
        m_cnt = m_T;
        m_chan = chan_in;
      end
      if (res_wr && !en) m_cfg = res_in;
      m_en_d = en;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      check("R3 busy", busy, m_cnt > 0);
      check("R3/R7 done", done, m_cnt == 1);
      check("R10 sample", sample, (m_cnt > 0) && ((m_T - m_cnt) < m_S));
      check("R2/R7 result", result, m_res);
      check("R9 chan_sel", chan_sel, m_chan);
      check("R9 sens_pwr", sens_pwr, sens_req & en);
      check("R4 res_mode", res_mode, m_cfg);
      if (m_cnt == 0) check("R10 dac idle", dac_word, 0);
      else check("R10 dac low bits", int'(dac_word) & ((1 << m_shift) - 1), 0);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_res(logic [1:0] r);
    res_in = r; res_wr = 1'b1; tick(1); res_wr = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    tick(1);
    while (busy && guard < 200) begin tick(1); guard++; end
    tick(1);
  endtask

  task automatic conv_by_enable(int v, logic [1:0] r, int e, logic [4:0] ch);
    en = 1'b0; tick(1);
    set_res(r);
    vin = v; smp_extra = 4'(e); chan_in = ch;
    en = 1'b1;
    wait_idle();
    check("R2 final result", result, v >> (2 * int'(r)));
  endtask

  initial begin
    tick(3);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 result", result, 0);
    check("R1 dac_word", dac_word, 0);
    check("R1 res_mode", res_mode, 0);
    check("R1 chan_sel", chan_sel, 0);
    rst_n = 1'b1;
    model_on = 1;
    tick(2);

    begin
      int vals[6] = '{0, 4095, 2048, 2047, 2730, 1365};
      for (int r = 0; r < 4; r++)
        foreach (vals[i]) conv_by_enable(vals[i], 2'(r), (i % 2) * 3, 5'(i + 12));
    end

    // R5: software start, trigger, nothing while disabled
    en = 1'b0; tick(1); set_res(2'b01); en = 1'b1; vin = 3000; wait_idle();
    vin = 1234; sw_start = 1'b1; tick(1); sw_start = 1'b0; wait_idle();
    check("R5 sw_start result", result, 1234 >> 2);
    vin = 777; chan_in = 5'd16; sens_req = 1'b1; trig = 1'b1; tick(1); trig = 1'b0; wait_idle();
    check("R5 trig result", result, 777 >> 2);
    check("R9 temp channel", chan_sel, 16);
    en = 1'b0; trig = 1'b1; sw_start = 1'b1; tick(2); trig = 1'b0; sw_start = 1'b0;
    check("R5 no start when disabled", busy, 0);

    // R4: resolution write while enabled ignored
    en = 1'b1; wait_idle();
    set_res(2'b11); tick(1);
    check("R4 locked", res_mode, 1);

    // R8: start during busy ignored
    vin = 4000; chan_in = 5'd17; sw_start = 1'b1; tick(1); sw_start = 1'b0;
    tick(4); chan_in = 5'd3; trig = 1'b1; sw_start = 1'b1; tick(2); trig = 1'b0; sw_start = 1'b0;
    wait_idle();
    check("R8 channel kept", chan_sel, 17);

    // R6: abort mid conversion
    vin = 100; sw_start = 1'b1; tick(1); sw_start = 1'b0; tick(8);
    en = 1'b0; tick(1);
    check("R6 aborted", busy, 0);
    tick(20);
    check("R6 result unchanged", result, 4000 >> 2);
    sens_req = 1'b0;
    tick(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule